// File: doc/BRIEF.md
# Eight-Channel Bipolar Pulser Control Front End

This block is the digital control logic for an eight-channel bipolar transmit pulser. Each channel takes two request bits, a push request and a pull request, and turns them into three gate enables for the output stage: positive drive, negative drive and a return-to-zero damping switch. At most one of the three is active at a time. A single output enable gates all channels, and a single retiming clock is shared by all of them.

The block runs on a free-running internal timebase. It synchronises the retiming clock into that timebase and watches it for edges. While the retiming clock toggles, the block is in registered mode. In that mode the channel requests present at each rising edge of the retiming clock are held and drive the outputs until the next rising edge. The requests pass through a delay line as deep as the synchroniser, so the captured word is the one that was present at the edge. When the retiming clock stays at one level, high or low, for a parameterised release window, the block returns to transparent mode. In transparent mode the outputs follow the requests combinationally. On reset, and on every change of mode, all outputs are forced off for one timebase cycle.

The retiming clock must show at least one rising edge before any request goes nonzero. All requests should return to zero before the clock is stopped.

Top module: `pulser_ctrl`

## Requirements
- R1: For a channel `c` with `push_i[c]=0` and `pull_i[c]=0`, with the output enable high and the block not in its all-off cycle, only `damp_en_o[c]` is 1. Bit `c` of every request and enable bus belongs to channel `c`.
- R2: With `push_i[c]=1` and `pull_i[c]=0`, only `pos_en_o[c]` is 1.
- R3: With `pull_i[c]=1` and `push_i[c]=0`, only `neg_en_o[c]` is 1.
- R4: With both `push_i[c]` and `pull_i[c]` at 1, all three enables of channel `c` are 0 (output floats).
- R5: While `oe_i` is 0, every enable of every channel is 0, whatever the mode and requests.
- R6: In transparent mode the enables follow the requests in the same cycle, without waiting for a clock edge. This holds whether the retiming clock rests low or rests high.
- R7: In registered mode the enables show the requests that were present at the last rising edge of the retiming clock. A change of the requests while that clock stays at one level, or at its falling edge, does not reach the outputs.
- R8: After a rising edge of the retiming clock that follows a quiet period, the block is in registered mode no later than `SYNC_STAGES+3` timebase cycles after the edge is first sampled.
- R9: After the last edge of the retiming clock, the block stays in registered mode for at least `RELEASE_CYCLES` timebase cycles. It is back in transparent mode within `RELEASE_CYCLES+SYNC_STAGES+4` cycles.
- R10: During reset and in the first timebase cycle after reset is released, all enables are 0. The block then starts in transparent mode.
- R11: Each change of mode forces all enables of all channels to 0 for exactly one timebase cycle.
- R12: `pos_en_o[c]` and `neg_en_o[c]` are never 1 together, and no more than one enable of a channel is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running internal timebase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_i | input | 1 | Global output enable, active high |
| rtclk_i | input | 1 | Retiming clock, sampled on the timebase |
| push_i | input | NCH | Per-channel positive drive request |
| pull_i | input | NCH | Per-channel negative drive request |
| pos_en_o | output | NCH | Positive drive enable per channel |
| neg_en_o | output | NCH | Negative drive enable per channel |
| damp_en_o | output | NCH | Return-to-zero damping enable per channel |

## Verification
Two functions can fall in the same cycle: the one-cycle all-off blanking at a mode change, and the capture of a fresh request word at a retiming rising edge. The bench provokes this by raising the retiming clock while an all-push word is applied in transparent mode. It then counts over the following cycles how many show every enable at zero; exactly one such cycle is expected, and after it the captured word is expected. Release is judged from the other side. After the last edge the requests are changed, and the outputs must still show the held word just before the release window ends and the new word a few cycles after it.

// File: rtl/pulser_pkg.sv
package pulser_pkg;

  typedef struct packed {
    logic pos;
    logic neg;
    logic damp;
  } drive_t;

  function automatic drive_t drive_decode(input logic push, input logic pull,
                                          input logic en);
    drive_t d;
    d.pos  = en & push & ~pull;
    d.neg  = en & pull & ~push;
    d.damp = en & ~push & ~pull;
    return d;
  endfunction

endpackage

// File: rtl/rt_sync.sv
module rt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic edge_o
);
  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its history
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign edge_o = sh_q[STAGES-1] ^ sh_q[STAGES];
endmodule

// File: rtl/activity_mon.sv
module activity_mon #(
  parameter int RELEASE_CYCLES = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic active_o
);
  localparam int CW = $clog2(RELEASE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RELEASE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= LIMIT;
    else if (edge_i)          cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign active_o = (cnt_q != LIMIT);
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic sync_o,
  output logic blank_o
);
  logic mode_q, prev_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= active_i;
      prev_q  <= mode_q;
      armed_q <= 1'b1;
    end
  end

  assign sync_o  = mode_q;
  assign blank_o = ~armed_q | (mode_q ^ prev_q);
endmodule

// File: rtl/retime_bank.sv
module retime_bank #(
  parameter int NCH    = 8,
  parameter int STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           capture_i,
  input  logic [NCH-1:0] push_i,
  input  logic [NCH-1:0] pull_i,
  output logic [NCH-1:0] push_o,
  output logic [NCH-1:0] pull_o
);
  // delay line matches the retiming clock synchroniser depth
  logic [STAGES-1:0][NCH-1:0] push_pipe_q, pull_pipe_q;
  logic [NCH-1:0] push_hold_q, pull_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_pipe_q <= '0;
      pull_pipe_q <= '0;
    end else begin
      push_pipe_q[0] <= push_i;
      pull_pipe_q[0] <= pull_i;
      for (int s = 1; s < STAGES; s++) begin
        push_pipe_q[s] <= push_pipe_q[s-1];
        pull_pipe_q[s] <= pull_pipe_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_hold_q <= '0;
      pull_hold_q <= '0;
    end else if (capture_i) begin
      push_hold_q <= push_pipe_q[STAGES-1];
      pull_hold_q <= pull_pipe_q[STAGES-1];
    end
  end

  assign push_o = push_hold_q;
  assign pull_o = pull_hold_q;
endmodule

// File: rtl/pulser_ctrl.sv
module pulser_ctrl #(
  parameter int NCH            = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int RELEASE_CYCLES = 30
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           oe_i,
  input  logic           rtclk_i,
  input  logic [NCH-1:0] push_i,
  input  logic [NCH-1:0] pull_i,
  output logic [NCH-1:0] pos_en_o,
  output logic [NCH-1:0] neg_en_o,
  output logic [NCH-1:0] damp_en_o
);
  import pulser_pkg::*;

  logic rise_det, edge_det, clk_active, sync_mode, blank;
  logic [NCH-1:0] held_push, held_pull, sel_push, sel_pull;
  logic gate_en;

  rt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .async_i(rtclk_i),
    .rise_o(rise_det),
    .edge_o(edge_det)
  );

  activity_mon #(.RELEASE_CYCLES(RELEASE_CYCLES)) u_act (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edge_det),
    .active_o(clk_active)
  );

  mode_ctrl u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(clk_active),
    .sync_o  (sync_mode),
    .blank_o (blank)
  );

  retime_bank #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(rise_det),
    .push_i   (push_i),
    .pull_i   (pull_i),
    .push_o   (held_push),
    .pull_o   (held_pull)
  );

  assign sel_push = sync_mode ? held_push : push_i;
  assign sel_pull = sync_mode ? held_pull : pull_i;
  assign gate_en  = oe_i & ~blank;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    drive_t drv;
    assign drv           = drive_decode(sel_push[ch], sel_pull[ch], gate_en);
    assign pos_en_o[ch]  = drv.pos;
    assign neg_en_o[ch]  = drv.neg;
    assign damp_en_o[ch] = drv.damp;
  end
endmodule

// File: rtl/pulser_ctrl_chk.sv
module pulser_ctrl_chk #(
  parameter int NCH            = 8,
  parameter int RELEASE_CYCLES = 30
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           oe_i,
  input logic [NCH-1:0] pos_en_o,
  input logic [NCH-1:0] neg_en_o,
  input logic [NCH-1:0] damp_en_o,
  input logic           sync_mode,
  input logic           blank,
  input logic           rise_det,
  input logic           edge_det
);
  localparam int IW = $clog2(RELEASE_CYCLES + 3);
  localparam logic [IW-1:0] SAT  = IW'(RELEASE_CYCLES + 2);
  localparam logic [IW-1:0] RELV = IW'(RELEASE_CYCLES);

  logic [IW-1:0] idle_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           idle_q <= SAT;
    else if (edge_det)     idle_q <= '0;
    else if (idle_q != SAT) idle_q <= idle_q + 1'b1;
  end

  // R12
  no_shoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_en_o & neg_en_o) == '0);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_excl
    // R12
    excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({pos_en_o[ch], neg_en_o[ch], damp_en_o[ch]}));
  end

  // R5
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> ((pos_en_o | neg_en_o | damp_en_o) == '0));

  // R11
  blank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank |-> ((pos_en_o | neg_en_o | damp_en_o) == '0));

  // R7
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode && $past(sync_mode) && !blank && !$past(blank) &&
     !$past(rise_det) && $stable(oe_i))
    |-> ($stable(pos_en_o) && $stable(neg_en_o) && $stable(damp_en_o)));

  // R8
  sync_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q != '0 && idle_q <= RELV) |-> sync_mode);

  // R9
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q == SAT) |-> !sync_mode);
endmodule

bind pulser_ctrl pulser_ctrl_chk #(
  .NCH(NCH),
  .RELEASE_CYCLES(RELEASE_CYCLES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .oe_i     (oe_i),
  .pos_en_o (pos_en_o),
  .neg_en_o (neg_en_o),
  .damp_en_o(damp_en_o),
  .sync_mode(sync_mode),
  .blank    (blank),
  .rise_det (rise_det),
  .edge_det (edge_det)
);

// File: tb/pulser_ctrl_tb_top.sv
module pulser_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int REL = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic oe = 1'b1;
  logic rtclk = 1'b0;
  logic [NCH-1:0] push = '0, pull = '0;
  logic [NCH-1:0] pos, neg, damp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pulser_ctrl #(.NCH(NCH), .SYNC_STAGES(2), .RELEASE_CYCLES(REL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .oe_i(oe), .rtclk_i(rtclk),
    .push_i(push), .pull_i(pull),
    .pos_en_o(pos), .neg_en_o(neg), .damp_en_o(damp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_word(input string tag, input logic [NCH-1:0] p,
                             input logic [NCH-1:0] n, input logic en);
    logic [NCH-1:0] ep, en_, ed;
    ep  = en ? (p & ~n) : '0;
    en_ = en ? (n & ~p) : '0;
    ed  = en ? (~p & ~n) : '0;
    checks++;
    if (pos !== ep || neg !== en_ || damp !== ed) begin
      errors++;
      $display("FAIL %s: pos=%h neg=%h damp=%h expected pos=%h neg=%h damp=%h",
               tag, pos, neg, damp, ep, en_, ed);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [NCH-1:0] ap, an, bp, bn;
    int zeros;
    push = '1; pull = '0;
    step(3);
    expect_word("R10 in reset", '0, '0, 1'b0);
    @(negedge clk); rst_ni = 1'b1; #1;
    expect_word("R10 first cycle after reset", '0, '0, 1'b0);
    step(1);
    expect_word("R10 R2 transparent after reset", '1, '0, 1'b1);

    // R1 R2 R3 R4 R6: every request combination, clock resting low
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk);
      push = v[7:0]; pull = v[15:8]; #1;
      expect_word("R1 R2 R3 R4 R6 transparent decode", push, pull, 1'b1);
    end

    // R5 in transparent mode
    oe = 1'b0;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      push = v[7:0]; pull = 8'(v * 29 + 5); #1;
      expect_word("R5 disabled transparent", push, pull, 1'b0);
    end
    oe = 1'b1;

    // R11 R8: entering registered mode blanks exactly one cycle
    @(negedge clk); push = '1; pull = '0; rtclk = 1'b1;
    zeros = 0;
    for (int c = 0; c < 8; c++) begin
      step(1);
      if ((pos | neg | damp) == '0) zeros++;
    end
    checks++;
    if (zeros != 1) begin
      errors++;
      $display("FAIL R11 blank cycles=%0d expected 1", zeros);
    end
    expect_word("R8 registered after entry", '1, '0, 1'b1);
    @(negedge clk); rtclk = 1'b0;
    step(3);

    // R7: capture on rise only
    for (int p = 0; p < 64; p++) begin
      ap = 8'(p * 37 + 11); an = 8'(p * 91 + 3);
      @(negedge clk); push = ap; pull = an; rtclk = 1'b1;
      step(4);
      expect_word("R7 captured at rise", ap, an, 1'b1);
      push = ~ap; pull = ~an;
      step(2);
      expect_word("R7 held while clock high", ap, an, 1'b1);
      rtclk = 1'b0;
      step(4);
      expect_word("R7 held across falling edge", ap, an, 1'b1);
      if (p == 20) begin
        oe = 1'b0; #1;
        expect_word("R5 disabled registered", ap, an, 1'b0);
        oe = 1'b1; #1;
        expect_word("R5 re-enabled registered", ap, an, 1'b1);
      end
    end

    // R9: release with the clock resting high
    ap = 8'h0f; an = 8'hf0; bp = 8'hf0; bn = 8'h0f;
    @(negedge clk); push = ap; pull = an; rtclk = 1'b1;
    step(1);
    push = bp; pull = bn;
    step(REL);
    expect_word("R9 still registered before window ends", ap, an, 1'b1);
    step(6);
    expect_word("R9 transparent after release", bp, bn, 1'b1);

    // R6 with the clock resting high
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      push = 8'(v * 53 + 7); pull = v[7:0]; #1;
      expect_word("R6 transparent clock high", push, pull, 1'b1);
    end

    finish_run();
  end
endmodule